// File: doc/BRIEF.md
# Pattern-Driven Variable Serial Clock Generator

This block produces the serial clock for an SPI master from the peripheral clock. Two divider values are packed into one divider word. With a divider value D, one half of a serial clock period lasts D+1 peripheral clocks, so the serial clock runs at the peripheral clock divided by 2*(D+1). In fixed mode every half-period uses divider 0. In variable mode a pattern word picks a divider for each half-period of the word. Bit k of the pattern, counting from 0 at the start of the word, selects the timing of half-period k: a 0 picks divider 0 and a 1 picks divider 1. The clock frequency can therefore change inside one word. Variable mode is meant for 16-bit words, where the 32 pattern bits cover the 16 serial clock cycles of one word.

The shift engine pulses `start_i` to begin a word and pulses `stop_i` to end it. The generator drives `sclk_o` at the idle level set by `cpol_i` whenever it is not running. It marks each edge with a one-cycle strobe: `lead_o` when the clock leaves its idle level and `trail_o` when the clock returns to it. The engine uses these strobes to launch and capture data. Slave-mode clocking is not handled here.

Top module: `varclk_gen`

## Requirements
- R1: After reset `sclk_o` is low (with `cpol_i` low), and both `lead_o` and `trail_o` are low.
- R2: While no word is running, `sclk_o` equals `cpol_i`, and it follows a change of `cpol_i` in the same cycle.
- R3: With `var_en_i` low, every half-period lasts D0+1 clocks. Divider 1 and the pattern have no effect. The first edge comes D0+1 clocks after the clock edge that samples `start_i`.
- R4: With `var_en_i` high, half-period k lasts D0+1 clocks when pattern bit k is 0 and D1+1 clocks when it is 1.
- R5: Every accepted start resets the pattern index to 0, whatever bit the previous word stopped on.
- R6: Half-periods 0, 2, 4 and so on end with `sclk_o` leaving the idle level, marked by `lead_o`. Half-periods 1, 3, 5 and so on end with `sclk_o` returning to idle, marked by `trail_o`. Each strobe is high for one cycle, in the same cycle that `sclk_o` shows the new level.
- R7: A `stop_i` pulse sampled inside a half-period lets that half-period finish. If `sclk_o` is away from idle at that point, it returns to idle with a `trail_o` strobe. If it is already at idle, no edge occurs. No further strobe occurs until the next start.
- R8: A `start_i` pulse while a word is running has no effect on the timing or the edges.
- R9: Divider 0 is taken from bits [DIV_W-1:0] of `div_i`, and divider 1 from bits [2*DIV_W-1:DIV_W].
- R10: `lead_o` and `trail_o` are never high in the same cycle.
- R11: After half-period PAT_W-1, the pattern index wraps to 0. Half-period PAT_W then uses pattern bit 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a word |
| stop_i | input | 1 | One-cycle request to end the word after the current half-period |
| cpol_i | input | 1 | Idle level of the serial clock |
| var_en_i | input | 1 | Selects variable (pattern-driven) timing |
| div_i | input | 2*DIV_W | Divider 1 in the upper half, divider 0 in the lower half |
| pattern_i | input | PAT_W | Per-half-period divider select |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe: clock has just left idle |
| trail_o | output | 1 | Strobe: clock has just returned to idle |

## Verification
The bench builds the block with its default widths: 16-bit dividers and a 32-bit pattern. This keeps the divider field split and the 32-step index wrap exactly as used with 16-bit words. It programs divider values from 0 to 7, so single-clock half-periods and mixed long/short patterns fit in short runs. A 34-half-period word pushes the index past its wrap point. Words that stop on both even and odd half-periods, with stop requests sampled both early and on the last clock of a half-period, cover both ends of the stop path.

// File: rtl/varclk_pkg.sv
package varclk_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_e;

  // Kind of edge produced when a half-period closes, given whether the
  // clock currently sits away from its idle level.
  function automatic edge_e edge_at_close(input logic away_from_idle);
    return away_from_idle ? EDGE_TRAIL : EDGE_LEAD;
  endfunction

endpackage

// File: rtl/varclk_sel.sv
module varclk_sel #(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32,
  localparam int IDX_W = $clog2(PAT_W)
) (
  input  logic                 var_en,
  input  logic [2*DIV_W-1:0]   div_word,
  input  logic [PAT_W-1:0]     pattern,
  input  logic [IDX_W-1:0]     idx,
  output logic [DIV_W-1:0]     limit
);

  // Divider 0 lives in the low field, divider 1 in the high field.
  function automatic logic [DIV_W-1:0] pick_div(
    input logic               en,
    input logic [2*DIV_W-1:0] w,
    input logic               pat_bit
  );
    if (en && pat_bit) return w[2*DIV_W-1:DIV_W];
    return w[DIV_W-1:0];
  endfunction

  assign limit = pick_div(var_en, div_word, pattern[idx]);

endmodule

// File: rtl/varclk_timer.sv
module varclk_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             half_done
);

  logic [DIV_W-1:0] cnt_q;

  // A half-period spans limit+1 clocks: count 0..limit.
  assign half_done = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || half_done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/varclk_phase.sv
module varclk_phase
  import varclk_pkg::*;
#(
  parameter int PAT_W = 32,
  localparam int IDX_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             half_done,
  output logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             away,
  output logic             lead,
  output logic             trail
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_W - 1);

  logic  start_acc;
  logic  stop_now;
  logic  pend_q;
  edge_e close_kind;

  assign start_acc  = start_i && !run;
  assign stop_now   = pend_q || stop_i;
  assign close_kind = edge_at_close(away);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      idx    <= '0;
      away   <= 1'b0;
      pend_q <= 1'b0;
      lead   <= 1'b0;
      trail  <= 1'b0;
    end else begin
      lead  <= 1'b0;
      trail <= 1'b0;
      if (start_acc) begin
        run    <= 1'b1;
        idx    <= '0;
        away   <= 1'b0;
        pend_q <= 1'b0;
      end else if (run) begin
        if (half_done) begin
          if (stop_now) begin
            run    <= 1'b0;
            pend_q <= 1'b0;
            idx    <= '0;
            if (away) begin
              away  <= 1'b0;
              trail <= 1'b1;
            end
          end else begin
            away  <= !away;
            idx   <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            lead  <= (close_kind == EDGE_LEAD);
            trail <= (close_kind == EDGE_TRAIL);
          end
        end else if (stop_i) begin
          pend_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/varclk_gen.sv
module varclk_gen #(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               cpol_i,
  input  logic               var_en_i,
  input  logic [2*DIV_W-1:0] div_i,
  input  logic [PAT_W-1:0]   pattern_i,
  output logic               sclk_o,
  output logic               lead_o,
  output logic               trail_o
);

  localparam int IDX_W = $clog2(PAT_W);

  logic             run_w;
  logic             half_done_w;
  logic             away_w;
  logic [IDX_W-1:0] idx_w;
  logic [DIV_W-1:0] limit_w;

  varclk_sel #(.DIV_W(DIV_W), .PAT_W(PAT_W)) u_sel (
    .var_en   (var_en_i),
    .div_word (div_i),
    .pattern  (pattern_i),
    .idx      (idx_w),
    .limit    (limit_w)
  );

  varclk_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .limit     (limit_w),
    .half_done (half_done_w)
  );

  varclk_phase #(.PAT_W(PAT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .half_done (half_done_w),
    .run       (run_w),
    .idx       (idx_w),
    .away      (away_w),
    .lead      (lead_o),
    .trail     (trail_o)
  );

  assign sclk_o = away_w ^ cpol_i;

endmodule

// File: rtl/varclk_chk.sv
module varclk_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o,
  input logic run,
  input logic half_done
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_o && trail_o)); // R10

  AST_LEAD_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    lead_o |-> (sclk_o != cpol_i)); // R6

  AST_TRAIL_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    trail_o |-> (sclk_o == cpol_i)); // R6

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sclk_o == cpol_i)); // R2

  AST_EDGE_ON_HALF_END: assert property (@(posedge clk) disable iff (!rst_n)
    ((sclk_o != $past(sclk_o)) && $stable(cpol_i)) |-> $past(half_done)); // R3

  AST_NO_LEAD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    lead_o |-> run); // R7

endmodule

bind varclk_gen varclk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpol_i    (cpol_i),
  .sclk_o    (sclk_o),
  .lead_o    (lead_o),
  .trail_o   (trail_o),
  .run       (run_w),
  .half_done (half_done_w)
);

// File: tb/sim_varclk_gen.sv
module sim_varclk_gen;

  localparam int DIV_W = 16;
  localparam int PAT_W = 32;

  typedef struct {
    int    t;
    bit    is_lead;
    string tag;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic               stop_i = 1'b0;
  logic               cpol_i = 1'b0;
  logic               var_en_i = 1'b0;
  logic [2*DIV_W-1:0] div_i = '0;
  logic [PAT_W-1:0]   pattern_i = '0;
  logic               sclk_o;
  logic               lead_o;
  logic               trail_o;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  varclk_gen #(.DIV_W(DIV_W), .PAT_W(PAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cpol_i(cpol_i), .var_en_i(var_en_i), .div_i(div_i),
    .pattern_i(pattern_i), .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // Monitor: pops one expected edge per observed strobe.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (lead_o && trail_o) check(1'b0, "R10 both strobes", 1, 0);
      if (lead_o || trail_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected edge", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.t, {e.tag, " edge time"}, cyc, e.t);
          check(lead_o == e.is_lead, {e.tag, " edge kind lead"}, int'(lead_o), int'(e.is_lead));
          check((sclk_o != cpol_i) == e.is_lead, {e.tag, " sclk level"}, int'(sclk_o), int'(e.is_lead ^ cpol_i));
        end
      end
    end
  end

  // Driver: runs one word of n half-periods, pushes the expected edges.
  task automatic run_word(input bit v, input int d0, input int d1,
                          input logic [PAT_W-1:0] pat, input int n,
                          input bit early, input bit poke, input string tag);
    int ts, t, len, prev, target, dmax;
    int tk[64];
    var_en_i  = v;
    div_i     = {d1[DIV_W-1:0], d0[DIV_W-1:0]};
    pattern_i = pat;
    start_i   = 1'b1;
    ts = cyc + 1;
    t  = ts;
    for (int k = 0; k < n; k++) begin
      bit sel;
      exp_t e;
      sel = v ? pat[k % PAT_W] : 1'b0;
      len = (sel ? d1 : d0) + 1;
      t   = t + len;
      tk[k] = t;
      if (!(k == n - 1 && (k % 2) == 0)) begin
        e.t = t; e.is_lead = ((k % 2) == 0); e.tag = tag;
        q.push_back(e);
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    prev   = (n >= 2) ? tk[n-2] : ts;
    target = early ? prev : tk[n-1] - 1;
    if (poke && target > ts + 1) begin
      wait_cyc(ts + 1);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_cyc(target);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    dmax = (d0 > d1) ? d0 : d1;
    wait_cyc(tk[n-1] + 3 * (dmax + 1) + 2);
    check(sclk_o == cpol_i, "R7 idle after stop", int'(sclk_o), int'(cpol_i));
    check(q.size() == 0, "R7 edges outstanding", q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclk_o == 1'b0, "R1 sclk at reset", int'(sclk_o), 0);
    check(!lead_o && !trail_o, "R1 strobes at reset", int'({lead_o, trail_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: idle level follows polarity
    cpol_i = 1'b1;
    #1;
    check(sclk_o == 1'b1, "R2 idle high", int'(sclk_o), 1);
    cpol_i = 1'b0;
    #1;
    check(sclk_o == 1'b0, "R2 idle low", int'(sclk_o), 0);
    @(negedge clk);

    // R3 fixed mode, divider 1 and pattern must not matter (also R9 low field)
    run_word(1'b0, 2, 7, 32'hFFFF_FFFF, 8, 1'b0, 1'b0, "R3");
    run_word(1'b0, 0, 5, 32'hAAAA_AAAA, 4, 1'b0, 1'b0, "R3");
    // R4 variable mode
    run_word(1'b1, 1, 4, 32'h0000_00B4, 8, 1'b0, 1'b0, "R4");
    // R9 divider 1 from the upper field
    run_word(1'b1, 0, 5, 32'h0000_0002, 4, 1'b0, 1'b0, "R9");
    // R6 with idle-high polarity
    cpol_i = 1'b1;
    @(negedge clk);
    run_word(1'b1, 2, 0, 32'h0000_0015, 6, 1'b0, 1'b0, "R6");
    cpol_i = 1'b0;
    @(negedge clk);
    // R5 index restarts each word
    run_word(1'b1, 0, 3, 32'h0000_0003, 3, 1'b0, 1'b0, "R5");
    run_word(1'b1, 0, 3, 32'h0000_0003, 3, 1'b0, 1'b0, "R5");
    // R11 wrap past the last pattern bit
    run_word(1'b1, 0, 2, 32'h8000_0001, 34, 1'b0, 1'b0, "R11");
    // R7 early stop requests, on even and odd half-periods
    run_word(1'b1, 3, 1, 32'h0000_0009, 5, 1'b1, 1'b0, "R7");
    run_word(1'b0, 3, 0, 32'h0, 6, 1'b1, 1'b0, "R7");
    run_word(1'b0, 0, 0, 32'h0, 1, 1'b1, 1'b0, "R7");
    // R8 start during a running word
    run_word(1'b1, 1, 2, 32'h0000_0066, 10, 1'b0, 1'b1, "R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule